// File: doc/BRIEF.md
# Single-Wire Peripheral Bus Command Transmitter

This block is the transmit half of a host controller for a single open-drain data line shared by keyboards, pointing devices and similar peripherals. When a request is accepted, the block sends a long attention low and a start bit. It then sends the command byte and a stop bit. If the command is a write to a device register, the block leaves the line released for a fixed gap. It then sends a second start bit, two data bytes and a final stop bit. A separate request produces one long low pulse that resets every device on the line.

Every bit takes one cell of 100 microsecond ticks. The value of a bit is carried by how that cell is split between low and released time. All timing counts pulses of an external one-microsecond tick, so the block works at any system clock that is faster than the tick. The output `drive_low` is high only when the line must be pulled low. Outside logic uses it as the enable of an open-drain pad. Reading device replies and handling service requests are done elsewhere.

Top module: `dbus_cmd_tx`

## Requirements
- R1: After reset and whenever no transfer is running, `drive_low`, `busy` and `done` are all 0.
- R2: A 0 bit holds the line low for 65 ticks and then releases it for 35 ticks.
- R3: A 1 bit holds the line low for 35 ticks and then releases it for 65 ticks.
- R4: A command transfer starts with one unbroken low of 800 ticks. This is 765 ticks of attention followed by the low part of a 1 start bit, and it is followed by 65 released ticks.
- R5: The command byte goes out bit 7 first, followed by a 0 stop bit. If `cmd[3:2]` is not `2'b10`, the transfer ends after the 35 released ticks of that stop bit.
- R6: If `cmd[3:2]` is `2'b10` (register write), the released time after the command stop bit is 35 + 200 = 235 ticks. It is followed by a 1 start bit, `data_hi` bit 7 first, `data_lo` bit 7 first and a 0 stop bit.
- R7: A bus reset request produces a single low of 3000 ticks and no bits, and then the transfer ends.
- R8: If `greset_req` and `req` are both high in the same idle cycle, the bus reset is performed and the command is not sent.
- R9: While `busy` is high, `req`, `greset_req` and changes on the byte inputs have no effect. The running transfer goes out exactly as it was captured, and no second transfer follows it.
- R10: `busy` rises in the cycle after a request is accepted. `done` is a one-cycle pulse in the cycle after the tick that ends the transfer, and `busy` is 0 in that same cycle.
- R11: During a transfer, `drive_low` changes only in the cycle after a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | One-microsecond timing pulse, one clock wide per microsecond |
| req | input | 1 | Start a command transfer (sampled while idle) |
| greset_req | input | 1 | Start a bus reset pulse (sampled while idle, wins over `req`) |
| cmd | input | 8 | Command byte: address in 7:4, type in 3:2, register in 1:0 |
| data_hi | input | 8 | First data byte of a register write |
| data_lo | input | 8 | Second data byte of a register write |
| drive_low | output | 1 | 1 = pull the line low, 0 = release it |
| busy | output | 1 | A transfer or bus reset is in progress |
| done | output | 1 | One-cycle pulse at the end of each transfer |

## Verification
The assertions assume that reset is applied before the first request. They also assume that the tick is a level sampled on each clock, and that the byte inputs need to be valid only in the cycle a request is accepted. The bench holds each request for a single clock and runs the tick either on every clock or with random gaps of up to two idle clocks. It changes the byte inputs and raises both requests in the middle of a transfer, to show that captured values are used. The length of each low and released stretch on the line is measured in ticks and compared with a sequence built from the requirements.

// File: rtl/dbus_tx_pkg.sv
package dbus_tx_pkg;

    localparam int SEG_W = 16;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ATTN,
        ST_CSTART,
        ST_CMD,
        ST_CSTOP,
        ST_GAP,
        ST_DSTART,
        ST_DATA,
        ST_DSTOP,
        ST_GRST
    } tx_state_e;

    // One timed piece of line activity: low for 'lo' ticks, then released
    // until 'tot' ticks have gone by since the piece began.
    typedef struct packed {
        logic [SEG_W-1:0] lo;
        logic [SEG_W-1:0] tot;
    } seg_t;

    function automatic logic is_write_cmd(input logic [7:0] c);
        return c[3:2] == 2'b10;
    endfunction

    function automatic seg_t make_seg(input int lo_t, input int tot_t);
        seg_t s;
        s.lo  = SEG_W'(lo_t);
        s.tot = SEG_W'(tot_t);
        return s;
    endfunction

endpackage

// File: rtl/dbus_seg_timer.sv
module dbus_seg_timer
    import dbus_tx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    input  seg_t seg,
    output logic seg_end,
    output logic pull
);

    logic [SEG_W-1:0] elapsed;

    // The piece ends on the tick that completes it, so the next piece
    // begins counting on the very next tick with no lost time.
    assign seg_end = run && tick && (elapsed == seg.tot - 1'b1);
    assign pull    = run && (elapsed < seg.lo);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            elapsed <= '0;
        end else if (seg_end) begin
            elapsed <= '0;
        end else if (tick) begin
            elapsed <= elapsed + 1'b1;
        end
    end

    // R11: count never runs past the current piece
    a_r11_elapsed_bound: assert property (@(posedge clk) disable iff (rst)
        run |-> (elapsed < seg.tot));

endmodule

// File: rtl/dbus_tx_seq.sv
module dbus_tx_seq
    import dbus_tx_pkg::*;
#(
    parameter int T_ZERO_LO = 65,
    parameter int T_ONE_LO  = 35,
    parameter int T_CELL    = 100,
    parameter int T_ATTN    = 765,
    parameter int T_GAP     = 200,
    parameter int T_GRST    = 3000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req,
    input  logic       greset_req,
    input  logic [7:0] cmd_in,
    input  logic [7:0] hi_in,
    input  logic [7:0] lo_in,
    input  logic       seg_end,
    output logic       busy,
    output logic       done,
    output seg_t       seg
);

    localparam int BYTE_LAST = 7;
    localparam int WORD_LAST = 15;

    tx_state_e   st;
    logic [7:0]  cmd_q;
    logic [15:0] dat_q;
    logic [3:0]  idx;
    logic        cur_bit;

    assign busy = (st != ST_IDLE);

    always_comb begin
        if (st == ST_DATA) cur_bit = dat_q[4'(WORD_LAST) - idx];
        else               cur_bit = cmd_q[3'(BYTE_LAST) - idx[2:0]];
    end

    always_comb begin
        unique case (st)
            ST_ATTN:              seg = make_seg(T_ATTN, T_ATTN);
            ST_CSTART, ST_DSTART: seg = make_seg(T_ONE_LO, T_CELL);
            ST_CMD, ST_DATA:      seg = make_seg(cur_bit ? T_ONE_LO : T_ZERO_LO, T_CELL);
            ST_CSTOP, ST_DSTOP:   seg = make_seg(T_ZERO_LO, T_CELL);
            ST_GAP:               seg = make_seg(0, T_GAP);
            ST_GRST:              seg = make_seg(T_GRST, T_GRST);
            default:              seg = make_seg(0, 1);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            cmd_q <= '0;
            dat_q <= '0;
            idx   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    idx <= '0;
                    if (greset_req) begin
                        st <= ST_GRST;
                    end else if (req) begin
                        st    <= ST_ATTN;
                        cmd_q <= cmd_in;
                        dat_q <= {hi_in, lo_in};
                    end
                end
                ST_ATTN:   if (seg_end) st <= ST_CSTART;
                ST_CSTART: if (seg_end) begin st <= ST_CMD; idx <= '0; end
                ST_CMD: if (seg_end) begin
                    if (idx == 4'(BYTE_LAST)) st <= ST_CSTOP;
                    else                      idx <= idx + 1'b1;
                end
                ST_CSTOP: if (seg_end) begin
                    if (is_write_cmd(cmd_q)) begin
                        st <= ST_GAP;
                    end else begin
                        st   <= ST_IDLE;
                        done <= 1'b1;
                    end
                end
                ST_GAP:    if (seg_end) st <= ST_DSTART;
                ST_DSTART: if (seg_end) begin st <= ST_DATA; idx <= '0; end
                ST_DATA: if (seg_end) begin
                    if (idx == 4'(WORD_LAST)) st <= ST_DSTOP;
                    else                      idx <= idx + 1'b1;
                end
                ST_DSTOP, ST_GRST: if (seg_end) begin
                    st   <= ST_IDLE;
                    done <= 1'b1;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R9: captured bytes stay fixed for the whole transfer
    a_r9_capture_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(cmd_q) && $stable(dat_q)));

    // R10: done lasts a single cycle
    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10: done marks the fall of busy
    a_r10_done_at_end: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    // R5: command bit index stays within one byte
    a_r5_cmd_index: assert property (@(posedge clk) disable iff (rst)
        (st == ST_CMD) |-> (idx <= 4'(BYTE_LAST)));

endmodule

// File: rtl/dbus_cmd_tx.sv
module dbus_cmd_tx
    import dbus_tx_pkg::*;
#(
    parameter int T_ZERO_LO = 65,
    parameter int T_CELL    = 100,
    parameter int T_LEAD    = 800,
    parameter int T_GAP     = 200,
    parameter int T_GRST    = 3000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       us_tick,
    input  logic       req,
    input  logic       greset_req,
    input  logic [7:0] cmd,
    input  logic [7:0] data_hi,
    input  logic [7:0] data_lo,
    output logic       drive_low,
    output logic       busy,
    output logic       done
);

    // A 1 bit is the mirror image of a 0 bit inside the cell; the attention
    // low is what remains of the lead-in once the start bit low is added.
    localparam int T_ONE_LO = T_CELL - T_ZERO_LO;
    localparam int T_ATTN   = T_LEAD - T_ONE_LO;

    seg_t seg;
    logic seg_end;

    dbus_tx_seq #(
        .T_ZERO_LO (T_ZERO_LO),
        .T_ONE_LO  (T_ONE_LO),
        .T_CELL    (T_CELL),
        .T_ATTN    (T_ATTN),
        .T_GAP     (T_GAP),
        .T_GRST    (T_GRST)
    ) i_seq (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .greset_req (greset_req),
        .cmd_in     (cmd),
        .hi_in      (data_hi),
        .lo_in      (data_lo),
        .seg_end    (seg_end),
        .busy       (busy),
        .done       (done),
        .seg        (seg)
    );

    dbus_seg_timer i_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (busy),
        .tick    (us_tick),
        .seg     (seg),
        .seg_end (seg_end),
        .pull    (drive_low)
    );

    // R1: line is released whenever idle
    a_r1_idle_release: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !drive_low);

    // R11: line level moves only after a tick while a transfer runs
    a_r11_tick_paced: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && (drive_low != $past(drive_low))) |-> $past(us_tick));

endmodule

// File: tb/test_dbus_cmd_tx.sv
module test_dbus_cmd_tx;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       us_tick = 1'b0;
    logic       req = 1'b0;
    logic       greset_req = 1'b0;
    logic [7:0] cmd = '0;
    logic [7:0] data_hi = '0;
    logic [7:0] data_lo = '0;
    logic       drive_low;
    logic       busy;
    logic       done;

    dbus_cmd_tx i_dbus_cmd_tx (
        .clk        (clk),
        .rst        (rst),
        .us_tick    (us_tick),
        .req        (req),
        .greset_req (greset_req),
        .cmd        (cmd),
        .data_hi    (data_hi),
        .data_lo    (data_lo),
        .drive_low  (drive_low),
        .busy       (busy),
        .done       (done)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int mon_checks = 0;
    int mon_errs = 0;
    int r11_bad = 0;
    bit slow_tick = 1'b0;

    int run_lo[$];
    int run_hi[$];
    int exp_lo[$];
    int exp_hi[$];

    // tick source
    initial begin
        int wait_n = 0;
        forever begin
            @(posedge clk);
            if (wait_n == 0) begin
                us_tick <= 1'b1;
                wait_n = slow_tick ? int'($urandom_range(0, 2)) : 0;
            end else begin
                us_tick <= 1'b0;
                wait_n--;
            end
        end
    end

    // line monitor: lengths of low and released stretches in ticks
    bit prev_low = 0, prev_busy = 0, prev_tick = 0, in_high = 0;
    int lcnt = 0, hcnt = 0;
    always @(negedge clk) begin
        if (rst) begin
            prev_low = 0; prev_busy = 0; prev_tick = 0; in_high = 0;
            lcnt = 0; hcnt = 0;
        end else begin
            if (busy && !prev_busy) begin
                run_lo.delete(); run_hi.delete();
                lcnt = 0; hcnt = 0; in_high = 0;
            end
            if (drive_low != prev_low) begin
                if (busy && prev_busy && !prev_tick) r11_bad++;
                if (prev_low) begin
                    run_lo.push_back(lcnt);
                    hcnt = 0;
                    in_high = 1;
                end else begin
                    if (in_high) run_hi.push_back(hcnt);
                    in_high = 0;
                    lcnt = 0;
                end
            end
            if (busy && us_tick) begin
                if (drive_low) lcnt++;
                else if (in_high) hcnt++;
            end
            if (done) begin
                mon_checks++;
                if (!prev_tick) begin
                    mon_errs++;
                    $display("FAIL R10: done without a tick in the prior cycle, actual tick=%0d expected 1", prev_tick);
                end
                if (in_high) run_hi.push_back(hcnt);
                in_high = 0;
            end
            prev_low = drive_low; prev_busy = busy; prev_tick = us_tick;
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors",
                 checks + mon_checks + 1, errors + mon_errs + 1);
        $finish;
    end

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic push_bit(input bit b);
        exp_lo.push_back(b ? 35 : 65);
        exp_hi.push_back(b ? 65 : 35);
    endtask

    task automatic build_exp(input logic [7:0] c, input logic [7:0] h, input logic [7:0] l,
                             input bit grst);
        exp_lo.delete(); exp_hi.delete();
        if (grst) begin
            exp_lo.push_back(3000);
            exp_hi.push_back(0);
        end else begin
            exp_lo.push_back(800);      // R4 attention plus start-bit low
            exp_hi.push_back(65);
            for (int i = 7; i >= 0; i--) push_bit(c[i]);
            exp_lo.push_back(65);       // command stop bit
            if (c[3:2] == 2'b10) begin
                exp_hi.push_back(235);  // R6 stop high plus gap
                push_bit(1'b1);
                for (int i = 7; i >= 0; i--) push_bit(h[i]);
                for (int i = 7; i >= 0; i--) push_bit(l[i]);
                push_bit(1'b0);
            end else begin
                exp_hi.push_back(35);
            end
        end
    endtask

    task automatic cmp_runs(input string tag);
        int bad_idx = -1;
        int a = 0, e = 0;
        if (run_lo.size() != exp_lo.size() || run_hi.size() != exp_hi.size()) begin
            check(1'b0, {tag, " run count"}, run_lo.size(), exp_lo.size());
            return;
        end
        for (int i = 0; i < exp_lo.size(); i++) begin
            if (bad_idx < 0 && run_lo[i] != exp_lo[i]) begin
                bad_idx = i; a = run_lo[i]; e = exp_lo[i];
            end
            if (bad_idx < 0 && run_hi[i] != exp_hi[i]) begin
                bad_idx = i; a = run_hi[i]; e = exp_hi[i];
            end
        end
        check(bad_idx < 0, {tag, " line waveform"}, a, e);
    endtask

    task automatic xfer(input logic [7:0] c, input logic [7:0] h, input logic [7:0] l,
                        input bit grst, input bit both, input bit interfere, input string tag);
        int guard = 0;
        build_exp(c, h, l, grst);
        @(negedge clk);
        cmd = c; data_hi = h; data_lo = l;
        req = !grst || both;
        greset_req = grst;
        @(negedge clk);
        req = 1'b0; greset_req = 1'b0;
        check(busy == 1'b1, {tag, " R10 busy after accept"}, busy, 1);
        if (interfere) begin
            repeat (300) @(negedge clk);
            cmd = ~c; data_hi = ~h; data_lo = ~l;
            req = 1'b1; greset_req = 1'b1;
            @(negedge clk);
            req = 1'b0; greset_req = 1'b0;
        end
        while (!done && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        check(busy == 1'b0, {tag, " R10 busy low with done"}, busy, 0);
        @(negedge clk);
        check(done == 1'b0, {tag, " R10 done single cycle"}, done, 0);
        cmp_runs(tag);
        if (interfere) begin
            bit quiet = 1'b1;
            repeat (40) begin
                @(negedge clk);
                if (busy || drive_low) quiet = 1'b0;
            end
            check(quiet, {tag, " R9 no follow-on transfer"}, !quiet, 0);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        // R1 reset state
        check(drive_low == 1'b0 && busy == 1'b0 && done == 1'b0, "R1 during reset",
              {drive_low, busy, done}, 0);
        rst = 1'b0;
        repeat (20) @(negedge clk);
        check(drive_low == 1'b0 && busy == 1'b0 && done == 1'b0, "R1 idle after reset",
              {drive_low, busy, done}, 0);

        // directed cases
        xfer(8'h2C, 8'h00, 8'h00, 0, 0, 0, "R4 R5 read command fast tick");
        slow_tick = 1'b1;
        xfer(8'h2A, 8'h00, 8'h05, 0, 0, 0, "R6 write command slow tick");
        xfer(8'h08, 8'h00, 8'h00, 0, 0, 0, "R2 zero bits");
        xfer(8'hFB, 8'hFF, 8'hFF, 0, 0, 0, "R3 one bits");
        xfer(8'h00, 8'h00, 8'h00, 1, 0, 0, "R7 bus reset");
        xfer(8'h3C, 8'h12, 8'h34, 1, 1, 0, "R8 reset wins over command");
        xfer(8'h3A, 8'hA5, 8'h5A, 0, 0, 1, "R9 requests ignored while busy");
        slow_tick = 1'b0;
        xfer(8'h00, 8'h00, 8'h00, 1, 0, 1, "R9 bus reset ignores requests");

        // random commands
        for (int k = 0; k < 5; k++) begin
            logic [7:0] c;
            c = 8'($urandom_range(0, 255));
            if (k[0]) c[3:2] = 2'b10;
            slow_tick = k[1];
            xfer(c, 8'($urandom_range(0, 255)), 8'($urandom_range(0, 255)), 0, 0, 0,
                 "R5 R6 random command");
        end

        check(r11_bad == 0, "R11 line changes only after a tick", r11_bad, 0);

        $display("Simulation finished: %0d checks, %0d errors",
                 checks + mon_checks, errors + mon_errs);
        $finish;
    end

endmodule